// File: doc/BRIEF.md
# ROM-Driven I2C Register Loader

This block is a write-only I2C bus master that brings up peripheral registers once after reset, with no processor involved. A byte position counter steps through a small table computed into a ROM. Most table positions are data bytes. Some fixed positions, set by parameter, are turned into bus start or stop events instead. A per-byte bit engine serialises each data byte onto SCL and SDA, most significant bit first. It then clocks a ninth acknowledge slot with SDA released, and it never samples that slot.

A single pass can load several devices. The default layout has the following positions:
- 0: start.
- 1: device address.
- 2: register address.
- 3 to 5: data.
- 6: stop.
- 7: fresh start.
- 8: second device address.
- 9: register address.
- 10: data.
- 11: final stop.

After the final stop the position counter returns to zero and both lines idle high. A done flag is raised and stays up until the next reset. External select bits form the high ROM address bits, so each select value picks a different table. The SCL rate comes from a clock divider: each bit lasts four quarter periods of `CLK_HZ/(4*SCL_HZ)` cycles.

Top module: `cfg_i2c_loader`

## Requirements
- R1: While reset is low, and after its release until the first bus event begins, SCL=1, SDA=1 and done=0.
- R2: The first bus activity after reset is a start: SDA falls while SCL is high.
- R3: Each data byte is sent most significant bit first as 8 SCL pulses, followed by a ninth SCL pulse during which SDA is held at 1. No acknowledge is sampled.
- R4: Outside start and stop events, SDA changes only while SCL is low.
- R5: The byte sent right after each start has its bit 0 (the read/write bit) forced to 0, whatever the table holds. All other bytes are sent exactly as stored.
- R6: Positions STOP1_POS and LAST_POS produce a stop (SDA rises while SCL is high). Position START2_POS produces a fresh start. The bytes between these events come from the table in position order.
- R7: After the stop at LAST_POS, done becomes 1 and stays 1, and SCL and SDA stay at 1 with no further activity until reset.
- R8: Table byte for select s and position p is `(((s << POS_W) + p) * 37 + 20) mod 256`. The tbl_sel input picks s.
- R9: During every data or acknowledge bit, SCL is high for exactly 2 quarter periods (2*QUARTER_CYC clocks).
- R10: A reset in the middle of a pass drives both lines high. After release the pass restarts from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_sel | input | SEL_W | Selects which table is sent (high ROM address bits) |
| scl_o | output | 1 | SCL level (1 = released/high) |
| sda_o | output | 1 | SDA level (1 = released/high) |
| done_o | output | 1 | High once the final stop has been sent |

## Verification
Each bus step is registered, so SCL and SDA move one clock after a quarter-period tick. An SCL high phase therefore spans exactly two ticks, or 2*QUARTER_CYC clocks. The done flag follows the last stop step by one clock. Rather than predicting absolute cycle numbers, the bench samples the lines on falling clock edges and decodes starts, stops, bits and acknowledge levels as they happen. It also measures each SCL high time in clocks, and then compares the decoded event list with one built from the table formula. Reset effects are checked at the first falling edge after reset is applied.

// File: rtl/cfg_i2c_pkg.sv
// Shared types and the table formula for the I2C register loader.
// Assumes: table content is a pure function of the flat ROM index.
package cfg_i2c_pkg;

    // Kind of bus action a table position produces
    typedef enum logic [1:0] {
        EV_START = 2'd0,
        EV_STOP  = 2'd1,
        EV_DATA  = 2'd2
    } ev_kind_t;

    // Table content for flat index {select, position}
    function automatic logic [7:0] table_byte(input int unsigned idx);
        int unsigned v;
        v = idx * 37 + 20;
        return 8'(v & 255);
    endfunction

endpackage

// File: rtl/cfg_i2c_tick.sv
// Free-running divider producing one-cycle quarter-bit ticks.
// Assumes: QUARTER_CYC >= 1; tick period is exactly QUARTER_CYC clocks.
module cfg_i2c_tick #(
    parameter int QUARTER_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
    localparam logic [CW-1:0] TOP = CW'(QUARTER_CYC - 1);

    logic [CW-1:0] cnt;

    // Count clocks and wrap at the quarter period
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == TOP) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == TOP);

    generate
        if (QUARTER_CYC > 1) begin : g_tick_chk
            // R9: ticks are isolated pulses, keeping SCL phases evenly spaced
            a_r9_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/cfg_i2c_table.sv
// Read-only byte table indexed by {select, position}; contents computed.
// Assumes: SEL_W + POS_W stays small (a few thousand entries at most).
module cfg_i2c_table
    import cfg_i2c_pkg::*;
#(
    parameter int SEL_W = 1,
    parameter int POS_W = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [7:0]       byte_o
);
    localparam int DEPTH = 1 << (SEL_W + POS_W);

    logic [7:0] rom [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_rom
            assign rom[i] = table_byte(i);
        end
    endgenerate

    // Asynchronous read of the selected entry
    assign byte_o = rom[{sel_i, pos_i}];
endmodule

// File: rtl/cfg_i2c_bitseq.sv
// Bit engine: turns one start, stop or data byte into SCL/SDA steps.
// Each action is 4 quarter steps; a data byte has 9 slots (8 bits + ack).
// Assumes: go_i is only raised while idle; acknowledge is never sampled.
module cfg_i2c_bitseq
    import cfg_i2c_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick_i,
    input  logic     go_i,
    input  ev_kind_t kind_i,
    input  logic [7:0] data_i,
    output logic     scl_o,
    output logic     sda_o,
    output logic     fin_o
);
    localparam logic [3:0] ACK_SLOT = 4'd8;

    logic       busy;
    ev_kind_t   kind_q;
    logic [7:0] shreg;
    logic [3:0] slot;
    logic [1:0] qtr;
    logic       scl_q, sda_q, fin_q;
    logic       last_step;

    assign last_step = (qtr == 2'd3) && ((kind_q != EV_DATA) || (slot == ACK_SLOT));

    // Step through quarter phases on each tick and drive the lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            kind_q <= EV_DATA;
            shreg  <= '0;
            slot   <= '0;
            qtr    <= '0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i && !busy) begin
                busy   <= 1'b1;
                kind_q <= kind_i;
                shreg  <= data_i;
                slot   <= '0;
                qtr    <= '0;
            end else if (busy && tick_i) begin
                unique case (kind_q)
                    EV_START: begin
                        scl_q <= (qtr != 2'd3);
                        sda_q <= (qtr < 2'd2);
                    end
                    EV_STOP: begin
                        scl_q <= (qtr != 2'd0);
                        sda_q <= (qtr >= 2'd2);
                    end
                    default: begin
                        if (qtr == 2'd0) begin
                            scl_q <= 1'b0;
                            sda_q <= (slot == ACK_SLOT) ? 1'b1 : shreg[7];
                        end else if (qtr == 2'd3) begin
                            scl_q <= 1'b0;
                            shreg <= {shreg[6:0], 1'b0};
                        end else begin
                            scl_q <= 1'b1;
                        end
                    end
                endcase
                qtr <= qtr + 2'd1;
                if (last_step) begin
                    busy  <= 1'b0;
                    fin_q <= 1'b1;
                end else if (qtr == 2'd3) begin
                    slot <= slot + 4'd1;
                end
            end
        end
    end

    assign scl_o = scl_q;
    assign sda_o = sda_q;
    assign fin_o = fin_q;

    // R4: SDA moves under high SCL only inside start/stop actions
    a_r4_sda_quiet_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |-> (kind_q != EV_DATA));

    // R3: acknowledge slot keeps SDA released once its first step has run
    a_r3_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind_q == EV_DATA && slot == ACK_SLOT && qtr != 2'd0) |-> sda_q);

    // R3: the engine never runs past the acknowledge slot
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (slot <= ACK_SLOT));
endmodule

// File: rtl/cfg_i2c_loader.sv
// Top: byte position counter, position decode into start/stop/data,
// read/write bit forcing, done flag. One pass per reset.
// Assumes: 0 < STOP1_POS < START2_POS < LAST_POS < 2**POS_W.
module cfg_i2c_loader
    import cfg_i2c_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int SCL_HZ     = 100_000,
    parameter int SEL_W      = 1,
    parameter int POS_W      = 4,
    parameter int STOP1_POS  = 6,
    parameter int START2_POS = 7,
    parameter int LAST_POS   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] tbl_sel,
    output logic             scl_o,
    output logic             sda_o,
    output logic             done_o
);
    localparam int QUARTER_CYC = CLK_HZ / (4 * SCL_HZ);
    localparam logic [POS_W-1:0] P_STOP1  = POS_W'(STOP1_POS);
    localparam logic [POS_W-1:0] P_START2 = POS_W'(START2_POS);
    localparam logic [POS_W-1:0] P_LAST   = POS_W'(LAST_POS);
    localparam logic [POS_W-1:0] P_ADDR1  = POS_W'(1);
    localparam logic [POS_W-1:0] P_ADDR2  = POS_W'(START2_POS + 1);

    logic [POS_W-1:0] pos;
    logic             go_q, done_q;
    logic             tick, fin;
    logic [7:0]       rom_byte, tx_byte;
    ev_kind_t         kind;
    logic             is_addr;

    cfg_i2c_tick #(.QUARTER_CYC(QUARTER_CYC)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    cfg_i2c_table #(.SEL_W(SEL_W), .POS_W(POS_W)) u_table (
        .sel_i  (tbl_sel),
        .pos_i  (pos),
        .byte_o (rom_byte)
    );

    // Decode the current position into an action and the byte to send
    always_comb begin
        if (pos == '0 || pos == P_START2)      kind = EV_START;
        else if (pos == P_STOP1 || pos == P_LAST) kind = EV_STOP;
        else                                   kind = EV_DATA;
        is_addr = (pos == P_ADDR1) || (pos == P_ADDR2);
        tx_byte = is_addr ? {rom_byte[7:1], 1'b0} : rom_byte;
    end

    cfg_i2c_bitseq u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .go_i   (go_q),
        .kind_i (kind),
        .data_i (tx_byte),
        .scl_o  (scl_o),
        .sda_o  (sda_o),
        .fin_o  (fin)
    );

    // Advance the position after each action; wrap and finish after the last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            go_q   <= 1'b1;
            done_q <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (fin) begin
                if (pos == P_LAST) begin
                    pos    <= '0;
                    done_q <= 1'b1;
                end else begin
                    pos  <= pos + 1'b1;
                    go_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;

    // R7: once finished the bus idles high
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (scl_o && sda_o));

    // R7: done stays set until reset
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);

    // R6: position never passes the final stop
    a_r6_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= P_LAST);

    // R7: no new action is launched after done
    a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !go_q);
endmodule

// File: tb/cfg_i2c_loader_tb.sv
// Directed bench: decodes the bus at falling clock edges and compares the
// decoded start/stop/byte list with one built from the table formula.
module cfg_i2c_loader_tb;
    localparam int Q      = 4;
    localparam int CLK_HZ = 50_000_000;
    localparam int SCL_HZ = CLK_HZ / (4 * Q);
    localparam int POS_W  = 4;
    localparam int STOP1  = 6;
    localparam int START2 = 7;
    localparam int LAST   = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] sel = 1'b0;
    logic scl, sda, done;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cfg_i2c_loader #(
        .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .SEL_W(1), .POS_W(POS_W),
        .STOP1_POS(STOP1), .START2_POS(START2), .LAST_POS(LAST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .tbl_sel(sel),
        .scl_o(scl), .sda_o(sda), .done_o(done)
    );

    // Bus decoder log: kind 0=start 1=stop 2=byte
    int lg_kind [64];
    int lg_val  [64];
    int lg_ack  [64];
    int lg_n = 0;
    int bitcnt = 0;
    int shv = 0;
    int hi_cnt = 0;
    int hi_bad = 0;
    int hi_seen = 0;
    int activity = 0;
    logic p_scl = 1'b1, p_sda = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            lg_n = 0; bitcnt = 0; shv = 0; hi_cnt = 0;
        end else begin
            if (scl != p_scl || sda != p_sda) activity++;
            if (p_scl && scl && p_sda && !sda) begin
                if (lg_n < 64) begin lg_kind[lg_n] = 0; lg_val[lg_n] = 0; lg_ack[lg_n] = 0; lg_n++; end
                bitcnt = 0; shv = 0;
            end else if (p_scl && scl && !p_sda && sda) begin
                if (lg_n < 64) begin lg_kind[lg_n] = 1; lg_val[lg_n] = 0; lg_ack[lg_n] = 0; lg_n++; end
                bitcnt = 0; shv = 0;
            end else if (!p_scl && scl) begin
                bitcnt++;
                if (bitcnt <= 8) shv = ((shv << 1) | int'(sda)) & 255;
                else begin
                    if (lg_n < 64) begin lg_kind[lg_n] = 2; lg_val[lg_n] = shv; lg_ack[lg_n] = int'(sda); lg_n++; end
                end
            end else if (p_scl && !scl && bitcnt >= 1) begin
                hi_seen++;
                if (hi_cnt != 2 * Q) hi_bad++;
                if (bitcnt >= 9) begin bitcnt = 0; shv = 0; end
            end
            if (scl) hi_cnt++; else hi_cnt = 0;
        end
        p_scl = scl; p_sda = sda;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_kind(input int p);
        if (p == 0 || p == START2) return 0;
        if (p == STOP1 || p == LAST) return 1;
        return 2;
    endfunction

    function automatic int exp_val(input int s, input int p);
        int v;
        v = (((s << POS_W) + p) * 37 + 20) % 256;
        if (p == 1 || p == START2 + 1) v = v & 254;
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    endtask

    task automatic compare_pass(input int s, input string tag);
        check({tag, " R6 event count"}, lg_n, LAST + 1);
        for (int p = 0; p <= LAST && p < lg_n; p++) begin
            check({tag, " R6 event kind"}, lg_kind[p], exp_kind(p));
            if (exp_kind(p) == 2) begin
                check({tag, " R8 R3 byte value"}, lg_val[p], exp_val(s, p));
                check({tag, " R3 ack slot high"}, lg_ack[p], 1);
            end
        end
    endtask

    // R1: reset state of lines and done
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 scl in reset", int'(scl), 1);
        check("R1 sda in reset", int'(sda), 1);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 scl after release", int'(scl), 1);
        check("R1 sda after release", int'(sda), 1);
        check("R1 done after release", int'(done), 0);
    endtask

    // R2 R3 R4 R5 R6 R9: full pass with table 0
    task automatic t_pass_sel0();
        hi_bad = 0; hi_seen = 0;
        sel = 1'b0;
        do_reset();
        wait_done();
        @(negedge clk);
        check("R7 done raised", int'(done), 1);
        check("R2 first event is start", (lg_n > 0) ? lg_kind[0] : -1, 0);
        check("R5 address rw bit forced", (lg_n > 1) ? (lg_val[1] & 1) : -1, 0);
        check("R5 odd data byte kept", (lg_n > 3) ? (lg_val[3] & 1) : -1, 1);
        compare_pass(0, "sel0");
        check("R9 scl high time violations", hi_bad, 0);
        check("R9 scl high phases seen", hi_seen, 8 * 9);
    endtask

    // R7: idle and done held after finish
    task automatic t_idle_after_done();
        int a0;
        a0 = activity;
        repeat (300) @(posedge clk);
        @(negedge clk);
        check("R7 no activity after done", activity - a0, 0);
        check("R7 scl idle high", int'(scl), 1);
        check("R7 sda idle high", int'(sda), 1);
        check("R7 done held", int'(done), 1);
    endtask

    // R8: alternate table select
    task automatic t_pass_sel1();
        sel = 1'b1;
        do_reset();
        wait_done();
        @(negedge clk);
        check("R8 done with sel1", int'(done), 1);
        compare_pass(1, "sel1");
    endtask

    // R10: reset in the middle of a pass
    task automatic t_reset_midway();
        sel = 1'b0;
        do_reset();
        repeat (400) @(posedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R10 scl high in reset", int'(scl), 1);
        check("R10 sda high in reset", int'(sda), 1);
        check("R10 done low in reset", int'(done), 0);
        @(posedge clk);
        rst_n = 1'b1;
        wait_done();
        @(negedge clk);
        check("R10 restarted pass done", int'(done), 1);
        compare_pass(0, "R10 restart");
    endtask

    initial begin
        t_reset_state();
        t_pass_sel0();
        t_idle_after_done();
        t_pass_sel1();
        t_reset_midway();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule